// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Tracker

This block sits beside a DDR SDRAM controller and watches the command stream it sends to the memory. It tracks four banks. For each bank it records whether the bank is idle or has a row open, and which row is open. It also runs down-counters for the activate-to-read delay, the activate-to-write delay, the minimum active time, the precharge time and the row cycle time. A shared counter enforces the spacing between activates to any two banks. From this state it drives one "command is legal now" flag per bank for each of four operations: activate, read, write and precharge.

When a command arrives while its flag is low, the command is not applied. The block raises a one-cycle violation pulse with a 3-bit reason code.

The block also models auto-precharge. A read or write with address bit 8 set closes the bank after the burst. The closing waits for the data to drain, and it never happens before the minimum active time has elapsed. A precharge with bit 8 set closes every open bank. All timing values, the CAS latency and the burst length are sampled while reset is held, so the controller can run at several clock settings.

Top module: `ddr_bank_tracker`

## Requirements
- R1: A command is taken only when `cs_n` is low. It is decoded from `{ras_n,cas_n,we_n}` as follows: activate is 011, read is 101, write is 100 and precharge is 010. Any other encoding, such as refresh (001), leaves all bank state unchanged and raises no violation.
- R2: While `cs_n` is high, the command pins have no effect and no violation is raised. A pending auto-precharge still completes on schedule.
- R3: An accepted activate sets the bank's bit in `bank_open` and stores the 11-bit `addr` in that bank's field of `open_row` (bank b occupies bits b*11+10 down to b*11).
- R4: After an activate at edge k, a read becomes legal at edge k+tRCD_rd and a write at edge k+tRCD_wr.
- R5: A precharge to an open bank becomes legal tRAS edges after its activate. A precharge at edge p closes the bank. The next activate to that bank is legal only when both of these have passed: p+tRP, and tRC edges after the previous activate.
- R6: After an accepted activate at edge k, no bank may be activated before edge k+tRRD.
- R7: A precharge with `addr[8]=1` closes every open bank, whatever the value of `ba`. It is rejected if any open bank is still inside tRAS or has an auto-precharge pending.
- R8: A read with `addr[8]=1` at edge k closes the bank at edge k+2*CL+BL/2. A write with `addr[8]=1` closes it at edge k+1+BL/2+tWR. In both cases the closing is delayed until tRAS has elapsed. While the auto-precharge is pending, commands to that bank are rejected.
- R9: A rejected command is not applied. In the cycle after its edge, `viol`=1 and `viol_code` gives the reason: 1 for an activate to an open bank, 2 for a read or write to an idle bank, 3 for an activate that is too early, 4 for a read that is too early, 5 for a write that is too early, 6 for a precharge that is too early, and 7 for a command to a bank with an auto-precharge pending. A precharge to an idle bank is a silent no-op.
- R10: The timing inputs, CAS latency and burst length are captured only while `rst_n` is low. Changes to them after reset have no effect.
- R11: After reset, all banks are idle, `act_ok` is all ones, every other legal flag is zero, and `viol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_trcd_rd | input | 5 | Activate-to-read delay in cycles |
| cfg_trcd_wr | input | 5 | Activate-to-write delay in cycles |
| cfg_tras | input | 5 | Minimum active time in cycles |
| cfg_trp | input | 5 | Precharge time in cycles |
| cfg_trc | input | 5 | Row cycle time in cycles |
| cfg_trrd | input | 5 | Activate-to-activate spacing across banks |
| cfg_twr | input | 5 | Write recovery before auto-precharge |
| cfg_cl | input | 3 | CAS latency (3 or 4) |
| cfg_bl | input | 4 | Burst length (2, 4 or 8) |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Row address, column address, bit 8 selects auto/all precharge |
| bank_open | output | 4 | Per-bank open flag |
| open_row | output | 44 | Open row of each bank, 11 bits per bank |
| act_ok | output | 4 | Activate legal per bank |
| rd_ok | output | 4 | Read legal per bank |
| wr_ok | output | 4 | Write legal per bank |
| pre_ok | output | 4 | Single-bank precharge legal per bank |
| viol | output | 1 | One-cycle pulse after a rejected command |
| viol_code | output | 3 | Reason for the rejection |

## Verification
The bench targets several off-by-one edges. It checks each legal flag on the cycle before it should rise and again on the cycle it does rise; a counter loaded with the full delay instead of one less would open every window a cycle late. It runs an auto-precharge whose drain delay ends before tRAS has elapsed, so a design that ignores the tRAS gate closes the bank one edge early. It repeats the read-with-auto-precharge case at CL 4 with BL 8, which catches a hard-wired delay. It changes the timing inputs after reset, which exposes a design that samples them continuously. It also presents an activate with chip select high and a refresh encoding with chip select low; a decoder that ignores chip select or matches too loosely would open a bank or raise a false violation.

// File: rtl/ddr_bank_tracker.sv
`timescale 1ns/1ps
module ddr_bank_tracker #(
  parameter int NB  = 4,
  parameter int RW  = 11,
  parameter int TW  = 5,
  parameter int APB = 8,
  localparam int BW = $clog2(NB),
  localparam int DW = TW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    cfg_trcd_rd,
  input  logic [TW-1:0]    cfg_trcd_wr,
  input  logic [TW-1:0]    cfg_tras,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_trc,
  input  logic [TW-1:0]    cfg_trrd,
  input  logic [TW-1:0]    cfg_twr,
  input  logic [2:0]       cfg_cl,
  input  logic [3:0]       cfg_bl,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BW-1:0]    ba,
  input  logic [RW-1:0]    addr,
  output logic [NB-1:0]    bank_open,
  output logic [NB*RW-1:0] open_row,
  output logic [NB-1:0]    act_ok,
  output logic [NB-1:0]    rd_ok,
  output logic [NB-1:0]    wr_ok,
  output logic [NB-1:0]    pre_ok,
  output logic             viol,
  output logic [2:0]       viol_code
);

  function automatic logic [TW-1:0] dn(input logic [TW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  logic [TW-1:0] trcd_rd_c, trcd_wr_c, tras_c, trp_c, trc_c, trrd_c, twr_c;
  logic [2:0]    cl_c;
  logic [3:0]    bl_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trcd_rd_c <= cfg_trcd_rd;
      trcd_wr_c <= cfg_trcd_wr;
      tras_c    <= cfg_tras;
      trp_c     <= cfg_trp;
      trc_c     <= cfg_trc;
      trrd_c    <= cfg_trrd;
      twr_c     <= cfg_twr;
      cl_c      <= cfg_cl;
      bl_c      <= cfg_bl;
    end
  end

  logic [DW-1:0] rd_dly, wr_dly;
  assign rd_dly = DW'({cl_c, 1'b0}) + DW'(bl_c >> 1);
  assign wr_dly = DW'(1) + DW'(bl_c >> 1) + DW'(twr_c);

  logic is_act, is_rd, is_wr, is_pre, pre_all;
  assign is_act  = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign is_rd   = !cs_n &&  ras_n && !cas_n &&  we_n;
  assign is_wr   = !cs_n &&  ras_n && !cas_n && !we_n;
  assign is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign pre_all = is_pre && addr[APB];

  logic [NB-1:0] open_q, ap_q;
  logic [TW-1:0] rrd_q;
  logic [2:0]    code;
  logic          bad;

  always_comb begin
    code = 3'd0;
    if (is_act) begin
      if (open_q[ba])       code = 3'd1;
      else if (!act_ok[ba]) code = 3'd3;
    end else if (is_rd || is_wr) begin
      if (!open_q[ba])              code = 3'd2;
      else if (ap_q[ba])            code = 3'd7;
      else if (is_rd && !rd_ok[ba]) code = 3'd4;
      else if (is_wr && !wr_ok[ba]) code = 3'd5;
    end else if (is_pre) begin
      if (pre_all) begin
        if (|(open_q & ap_q))         code = 3'd7;
        else if (|(open_q & ~pre_ok)) code = 3'd6;
      end else if (open_q[ba] && !pre_ok[ba]) begin
        code = ap_q[ba] ? 3'd7 : 3'd6;
      end
    end
  end

  assign bad       = (code != 3'd0);
  assign bank_open = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q     <= '0;
      viol      <= 1'b0;
      viol_code <= 3'd0;
    end else begin
      rrd_q     <= (is_act && !bad) ? dn(trrd_c) : dn(rrd_q);
      viol      <= bad;
      viol_code <= code;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          open_r, ap_r, hit, fire, close;
    logic [RW-1:0] row_r;
    logic [TW-1:0] rcdr_r, rcdw_r, ras_r, rp_r, rc_r;
    logic [DW-1:0] apc_r;

    assign hit   = (ba == BW'(b));
    assign fire  = ap_r && (apc_r == '0) && (ras_r == '0);
    assign close = fire || (is_pre && !bad && open_r && (pre_all || hit));

    assign open_q[b] = open_r;
    assign ap_q[b]   = ap_r;
    assign open_row[b*RW +: RW] = row_r;
    assign act_ok[b] = !open_r && (rp_r == '0) && (rc_r == '0) && (rrd_q == '0);
    assign rd_ok[b]  = open_r && !ap_r && (rcdr_r == '0);
    assign wr_ok[b]  = open_r && !ap_r && (rcdw_r == '0);
    assign pre_ok[b] = open_r && !ap_r && (ras_r == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        ap_r   <= 1'b0;
        row_r  <= '0;
        rcdr_r <= '0;
        rcdw_r <= '0;
        ras_r  <= '0;
        rp_r   <= '0;
        rc_r   <= '0;
        apc_r  <= '0;
      end else begin
        rcdr_r <= dn(rcdr_r);
        rcdw_r <= dn(rcdw_r);
        ras_r  <= dn(ras_r);
        rp_r   <= dn(rp_r);
        rc_r   <= dn(rc_r);
        apc_r  <= (apc_r == '0) ? '0 : apc_r - 1'b1;
        if (is_act && !bad && hit) begin
          open_r <= 1'b1;
          row_r  <= addr;
          rcdr_r <= dn(trcd_rd_c);
          rcdw_r <= dn(trcd_wr_c);
          ras_r  <= dn(tras_c);
          rc_r   <= dn(trc_c);
        end
        if (close) begin
          open_r <= 1'b0;
          ap_r   <= 1'b0;
          rp_r   <= dn(trp_c);
        end
        if ((is_rd || is_wr) && !bad && hit && addr[APB]) begin
          ap_r  <= 1'b1;
          apc_r <= (is_rd ? rd_dly : wr_dly) - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
`timescale 1ns/1ps
module ddr_bank_tracker_chk #(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [BW-1:0] ba,
  input logic          ap,
  input logic [NB-1:0] bank_open,
  input logic [NB-1:0] act_ok,
  input logic [NB-1:0] pre_ok,
  input logic          viol,
  input logic [2:0]    viol_code
);
  logic c_act, c_rw, c_pre;
  assign c_act = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign c_rw  = !cs_n &&  ras_n && !cas_n;
  assign c_pre = !cs_n && !ras_n &&  cas_n && !we_n;

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && act_ok[ba]) |=> bank_open[$past(ba)]);

  assert_cs_high_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !viol);

  assert_idle_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rw && !bank_open[ba]) |=> (viol && viol_code == 3'd2));

  assert_act_on_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && bank_open[ba]) |=> (viol && viol_code == 3'd1));

  assert_early_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && !bank_open[ba] && !act_ok[ba]) |=> (viol && viol_code == 3'd3));

  assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && !ap && pre_ok[ba]) |=> !bank_open[$past(ba)]);

  assert_pre_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && ap && (&(pre_ok | ~bank_open))) |=> (bank_open == '0));
endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .ap(addr[APB]), .bank_open(bank_open),
  .act_ok(act_ok), .pre_ok(pre_ok), .viol(viol), .viol_code(viol_code)
);

// File: tb/ddr_bank_tracker_tb_top.sv
`timescale 1ns/1ps
module ddr_bank_tracker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] trcd_rd, trcd_wr, tras, trp, trc, trrd, twr;
  logic [2:0] cl;
  logic [3:0] bl;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [10:0] addr = 11'd0;
  logic [3:0]  bank_open, act_ok, rd_ok, wr_ok, pre_ok;
  logic [43:0] open_row;
  logic        viol;
  logic [2:0]  viol_code;

  typedef struct { int at; int kind; logic [15:0] exp; string req; } item_t;
  item_t q[$];
  int edges = 0, n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam int K_ACT = 0, K_RD = 1, K_WR = 2, K_PRE = 3, K_OPEN = 4, K_VIOL = 5, K_ROW = 6;

  always #10 clk = ~clk;

  ddr_bank_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_trcd_rd(trcd_rd), .cfg_trcd_wr(trcd_wr), .cfg_tras(tras), .cfg_trp(trp),
    .cfg_trc(trc), .cfg_trrd(trrd), .cfg_twr(twr), .cfg_cl(cl), .cfg_bl(bl),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_row(open_row), .act_ok(act_ok), .rd_ok(rd_ok),
    .wr_ok(wr_ok), .pre_ok(pre_ok), .viol(viol), .viol_code(viol_code)
  );

  function automatic logic [15:0] getv(int k);
    case (k)
      K_ACT:   return {12'd0, act_ok};
      K_RD:    return {12'd0, rd_ok};
      K_WR:    return {12'd0, wr_ok};
      K_PRE:   return {12'd0, pre_ok};
      K_OPEN:  return {12'd0, bank_open};
      K_VIOL:  return {12'd0, viol, viol_code};
      default: return {5'd0, open_row[(k-K_ROW)*11 +: 11]};
    endcase
  endfunction

  task automatic ex(int k, logic [15:0] v, string r);
    item_t it;
    it.at = edges; it.kind = k; it.exp = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic cmd(logic c, logic r, logic ca, logic w, logic [1:0] b, logic [10:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(posedge clk);
    edges++;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) cmd(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 11'd0);
  endtask
  task automatic act(logic [1:0] b, logic [10:0] row); cmd(1'b0, 1'b0, 1'b1, 1'b1, b, row); endtask
  task automatic rd(logic [1:0] b, logic a8); cmd(1'b0, 1'b1, 1'b0, 1'b1, b, {2'b00, a8, 8'h05}); endtask
  task automatic wr(logic [1:0] b, logic a8); cmd(1'b0, 1'b1, 1'b0, 1'b0, b, {2'b00, a8, 8'h09}); endtask
  task automatic pre(logic [1:0] b, logic a8); cmd(1'b0, 1'b0, 1'b1, 1'b0, b, {2'b00, a8, 8'h00}); endtask

  task automatic do_reset(logic [2:0] c, logic [3:0] b);
    @(negedge clk);
    rst_n = 1'b0;
    trcd_rd = 5'd4; trcd_wr = 5'd2; tras = 5'd8; trp = 5'd4;
    trc = 5'd12; trrd = 5'd2; twr = 5'd2; cl = c; bl = b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= edges) begin
      item_t it;
      logic [15:0] g;
      it = q.pop_front();
      g = getv(it.kind);
      n_run++;
      if (g !== it.exp) begin
        n_fail++;
        $display("FAIL %s: kind %0d after edge %0d got %h expected %h", it.req, it.kind, it.at, g, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(3'd3, 4'd4);
    ex(K_ACT, 16'hF, "R11"); ex(K_OPEN, 16'h0, "R11"); ex(K_VIOL, 16'h0, "R11"); ex(K_RD, 16'h0, "R11");
    trcd_rd = 5'd1; tras = 5'd2; trp = 5'd1;               // R10: post-reset changes must be ignored
    act(2'd0, 11'h155);                                       // E1
    ex(K_OPEN, 16'h1, "R3"); ex(K_ROW + 0, 16'h155, "R3"); ex(K_ACT, 16'h0, "R6");
    ex(K_RD, 16'h0, "R10"); ex(K_WR, 16'h0, "R4");
    nop(1);                                                   // E2
    ex(K_WR, 16'h1, "R4"); ex(K_ACT, 16'hE, "R6"); ex(K_RD, 16'h0, "R4");
    rd(2'd0, 1'b0);                                           // E3 early read
    ex(K_VIOL, 16'hC, "R9"); ex(K_RD, 16'h0, "R4");
    wr(2'd0, 1'b0);                                           // E4
    ex(K_VIOL, 16'h0, "R4"); ex(K_RD, 16'h1, "R4");
    nop(2);                                                   // E5..E6
    pre(2'd0, 1'b0);                                          // E7 early precharge
    ex(K_VIOL, 16'hE, "R5"); ex(K_OPEN, 16'h1, "R9");
    nop(1);                                                   // E8
    ex(K_PRE, 16'h1, "R5"); ex(K_VIOL, 16'h0, "R5");
    pre(2'd0, 1'b0);                                          // E9
    ex(K_OPEN, 16'h0, "R5"); ex(K_ACT, 16'hE, "R5");
    nop(1);                                                   // E10
    act(2'd0, 11'h100);                                       // E11 early activate
    ex(K_VIOL, 16'hB, "R5"); ex(K_OPEN, 16'h0, "R9");
    nop(1);                                                   // E12
    ex(K_ACT, 16'hF, "R5");
    act(2'd1, 11'h2AA);                                       // E13
    ex(K_OPEN, 16'h2, "R3"); ex(K_ROW + 1, 16'h2AA, "R3"); ex(K_ACT, 16'h0, "R6");
    act(2'd2, 11'h011);                                       // E14 inside tRRD
    ex(K_VIOL, 16'hB, "R6"); ex(K_OPEN, 16'h2, "R6");
    act(2'd1, 11'h003);                                       // E15 activate on open bank
    ex(K_VIOL, 16'h9, "R9"); ex(K_ROW + 1, 16'h2AA, "R9"); ex(K_ACT, 16'hD, "R6");
    cmd(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 11'h044);               // E16 activate with cs high
    ex(K_OPEN, 16'h2, "R2"); ex(K_VIOL, 16'h0, "R2");
    cmd(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 11'h000);               // E17 refresh encoding
    ex(K_OPEN, 16'h2, "R1"); ex(K_VIOL, 16'h0, "R1");
    rd(2'd2, 1'b0);                                           // E18 read idle bank
    ex(K_VIOL, 16'hA, "R9");
    act(2'd3, 11'h7FF);                                       // E19
    ex(K_OPEN, 16'hA, "R3"); ex(K_ROW + 3, 16'h7FF, "R3");
    pre(2'd1, 1'b1);                                          // E20 precharge-all too early
    ex(K_VIOL, 16'hE, "R7"); ex(K_OPEN, 16'hA, "R7");
    nop(6);                                                   // E21..E26
    ex(K_PRE, 16'hA, "R5");
    pre(2'd2, 1'b1);                                          // E27 precharge-all, ba names idle bank
    ex(K_OPEN, 16'h0, "R7"); ex(K_VIOL, 16'h0, "R7");
    act(2'd0, 11'h0A0);                                       // E28
    ex(K_OPEN, 16'h1, "R3");
    nop(3);                                                   // E29..E31
    rd(2'd0, 1'b1);                                           // E32 read with auto-precharge
    ex(K_VIOL, 16'h0, "R8"); ex(K_OPEN, 16'h1, "R8");
    rd(2'd0, 1'b0);                                           // E33 pending bank
    ex(K_VIOL, 16'hF, "R8");
    for (int i = 0; i < 6; i++) cmd(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 11'h000); // E34..E39
    ex(K_OPEN, 16'h1, "R8");
    cmd(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 11'h000);               // E40
    ex(K_OPEN, 16'h0, "R2"); ex(K_ACT, 16'hE, "R8");
    nop(3);                                                   // E41..E43
    ex(K_ACT, 16'hF, "R8");
    act(2'd1, 11'h123);                                       // E44
    nop(1);                                                   // E45
    wr(2'd1, 1'b1);                                           // E46 write with auto-precharge
    ex(K_VIOL, 16'h0, "R8");
    nop(5);                                                   // E47..E51
    ex(K_OPEN, 16'h2, "R8");
    nop(1);                                                   // E52 tRAS gate releases
    ex(K_OPEN, 16'h0, "R8");
    do_reset(3'd4, 4'd8);
    ex(K_ACT, 16'hF, "R11"); ex(K_OPEN, 16'h0, "R11"); ex(K_VIOL, 16'h0, "R11");
    act(2'd2, 11'h3C3);                                       // F1
    nop(3);                                                   // F2..F4
    rd(2'd2, 1'b1);                                           // F5
    ex(K_VIOL, 16'h0, "R8");
    nop(11);                                                  // F6..F16
    ex(K_OPEN, 16'h4, "R8");
    nop(1);                                                   // F17
    ex(K_OPEN, 16'h0, "R8");
    nop(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule